// File: doc/BRIEF.md
# Segmented Flash Erase/Program Controller

This block sequences every access that a processor makes to an on-chip flash array that is split into segments of two sizes. Two small information segments of 128 bytes each sit at the bottom of the byte address space. Above them sit `N_MAIN` main segments of 512 bytes each. The processor presents one operation at a time, made of an operation code, a byte address and a data word. The controller turns it into read, program-word and range-erase strobes on a 16-bit array port.

Programming works read-modify-write and may only clear bits. A byte program touches one lane of the word, and a word program writes the whole aligned word. Erase works on one segment, on the whole main array with the information segments kept, or on the whole array. Program and erase hold `busy` for a fixed number of cycles, which parameters set. A rejected or ill-timed request raises a sticky violation flag, and an enable gates that flag onto an interrupt line.

Top module: `flash_seq_ctl`

## Requirements
- R1: Byte map: information segment A covers bytes 0x000–0x07F and B covers 0x080–0x0FF. Main segment k covers 0x100+512·k up to 0x2FF+512·k. Any byte address at or above 256+512·N_MAIN is out of range. A 16-bit array word holds the even byte in bits 7:0 and the odd byte in bits 15:8.
- R2: Operation code 0 (read) on an idle controller puts the array word that holds the addressed byte on `rd_data`, with `rd_valid` high, in the cycle after acceptance. Address bit 0 is ignored.
- R3: Operation code 3 (segment erase) sets every byte of the segment holding the address to 0xFF, using the 128-byte size for information segments and the 512-byte size for main segments. All other bytes stay unchanged.
- R4: Operation code 4 sets every main byte to 0xFF and leaves both information segments unchanged. Operation code 5 sets every byte of the array to 0xFF. Both codes ignore the address.
- R5: Operation code 1 (byte program) replaces the addressed byte by the AND of its old value with `op_wdata[7:0]` and leaves the other byte of the word unchanged. A later program can never set a bit back to one.
- R6: Operation code 2 (word program) at an even address replaces the word by the AND of its old value with `op_wdata`. At an odd address the request is rejected: the flag is set in the next cycle, `busy` stays low and the array is unchanged.
- R7: After acceptance, a program holds `busy` high for PROG_CYC+2 cycles and an erase holds it for ERASE_CYC+1 cycles. Both counts start in the cycle after the accepting edge. `busy` and the flag are low after reset.
- R8: Any operation presented while `busy` is high is a violation. A read then returns FILLER with `rd_valid` in the next cycle, and any other operation is dropped without touching the array.
- R9: An out-of-range address on codes 0–3, or a reserved code 6 or 7, is a violation. Such a read returns FILLER, and nothing reaches the array.
- R10: The violation flag stays set until `viol_clr` is pulsed. A new violation in the same cycle as `viol_clr` wins. `viol_irq` is high exactly when the flag and `viol_irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | Operation code (0 read, 1 byte program, 2 word program, 3 segment erase, 4 main erase, 5 full erase) |
| op_addr | input | ADDR_W | Byte address |
| op_wdata | input | 16 | Program data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data or FILLER |
| busy | output | 1 | Program or erase in progress |
| viol_clr | input | 1 | Clears the violation flag |
| viol_irq_en | input | 1 | Interrupt enable for the violation flag |
| viol_flag | output | 1 | Sticky access-violation flag |
| viol_irq | output | 1 | Violation interrupt |
| arr_rd | output | 1 | Array read strobe; data is due the next cycle |
| arr_wr | output | 1 | Array word write strobe |
| arr_ers | output | 1 | Array range erase strobe |
| arr_addr | output | ADDR_W-1 | Array word address for read and write |
| arr_wdata | output | 16 | Array write data |
| arr_ers_lo | output | ADDR_W-1 | First word of the erase range |
| arr_ers_hi | output | ADDR_W-1 | Last word of the erase range |
| arr_rdata | input | 16 | Array read data, registered by the array |

## Verification
Read data and FILLER are due in the cycle after the accepting edge, and the violation flag appears in that same cycle. The bench therefore drives each request on a falling edge and samples at the next falling edge. The `busy` length is measured by counting falling edges while it stays high and comparing with PROG_CYC+2 or ERASE_CYC+1. Array contents are checked with full read sweeps of every word, issued only once `busy` has dropped. Each sweep is compared against a reference image that the bench updates arithmetically from the segment geometry.

// File: rtl/flash_seq_pkg.sv
// Shared constants and types for the segmented flash controller.
// Assumes a 16-bit array word and fixed 128/512-byte segment sizes.
package flash_seq_pkg;
    localparam int INFO_SEG_B = 128;
    localparam int MAIN_SEG_B = 512;
    localparam int INFO_B     = 2 * INFO_SEG_B;

    localparam logic [2:0] OP_READ  = 3'd0;
    localparam logic [2:0] OP_PBYTE = 3'd1;
    localparam logic [2:0] OP_PWORD = 3'd2;
    localparam logic [2:0] OP_ESEG  = 3'd3;
    localparam logic [2:0] OP_EMAIN = 3'd4;
    localparam logic [2:0] OP_EALL  = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRD,
        ST_PWR,
        ST_ERS,
        ST_WAIT
    } fsm_e;
endpackage

// File: rtl/flash_seq_decode.sv
// Operation and address decoder: classifies the operation code, checks
// the byte address against the array size and computes the inclusive
// word range an erase covers. Purely combinational.
module flash_seq_decode
    import flash_seq_pkg::*;
#(
    parameter int N_MAIN  = 4,
    parameter int ADDR_W  = 12,
    parameter int WORD_AW = 11
) (
    input  logic [2:0]         op,
    input  logic [ADDR_W-1:0]  addr,
    output logic               known,
    output logic               needs_addr,
    output logic               is_prog,
    output logic               is_erase,
    output logic               in_range,
    output logic [WORD_AW-1:0] rng_lo,
    output logic [WORD_AW-1:0] rng_hi
);
    localparam int TOTAL_B    = INFO_B + N_MAIN * MAIN_SEG_B;
    localparam int TOTAL_W    = TOTAL_B / 2;
    localparam int INFO_W     = INFO_B / 2;
    localparam int INFO_SH    = $clog2(INFO_SEG_B);
    localparam int MAIN_SH    = $clog2(MAIN_SEG_B);
    localparam int INFO_SEG_W = INFO_SEG_B / 2;
    localparam int MAIN_SEG_W = MAIN_SEG_B / 2;

    logic [ADDR_W-1:0]  off;
    logic [WORD_AW-1:0] seg_lo;
    logic [WORD_AW-1:0] seg_hi;

    // Segment bounds of the addressed byte, for either segment size.
    always_comb begin
        off = addr - ADDR_W'(INFO_B);
        if (addr < ADDR_W'(INFO_B)) begin
            seg_lo = WORD_AW'((addr >> INFO_SH) << (INFO_SH - 1));
            seg_hi = seg_lo + WORD_AW'(INFO_SEG_W - 1);
        end else begin
            seg_lo = WORD_AW'(INFO_W) + WORD_AW'((off >> MAIN_SH) << (MAIN_SH - 1));
            seg_hi = seg_lo + WORD_AW'(MAIN_SEG_W - 1);
        end
    end

    assign in_range = (addr < ADDR_W'(TOTAL_B));

    // Operation classification and erase range selection.
    always_comb begin
        known      = 1'b1;
        needs_addr = 1'b0;
        is_prog    = 1'b0;
        is_erase   = 1'b0;
        rng_lo     = '0;
        rng_hi     = '0;
        case (op)
            OP_READ:  needs_addr = 1'b1;
            OP_PBYTE, OP_PWORD: begin
                needs_addr = 1'b1;
                is_prog    = 1'b1;
            end
            OP_ESEG: begin
                needs_addr = 1'b1;
                is_erase   = 1'b1;
                rng_lo     = seg_lo;
                rng_hi     = seg_hi;
            end
            OP_EMAIN: begin
                is_erase = 1'b1;
                rng_lo   = WORD_AW'(INFO_W);
                rng_hi   = WORD_AW'(TOTAL_W - 1);
            end
            OP_EALL: begin
                is_erase = 1'b1;
                rng_lo   = '0;
                rng_hi   = WORD_AW'(TOTAL_W - 1);
            end
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_seq_timer.sv
// Down-counter that times the program and erase pulses.
// Assumes load_val is one less than the wanted number of wait cycles.
module flash_seq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    p_timer_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> !$stable(cnt));
endmodule

// File: rtl/flash_seq_viol.sv
// Sticky access-violation flag with interrupt gating.
// Assumes a set and a clear in the same cycle leave the flag set.
module flash_seq_viol (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Hold the flag until cleared; a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (set)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set));
endmodule

// File: rtl/flash_seq_ctl.sv
// Segmented flash controller top. Accepts one operation at a time,
// rejects malformed or ill-timed requests, and drives read,
// read-modify-write program and range-erase strobes on a 16-bit array
// port. Assumes the array registers read data one cycle after arr_rd.
module flash_seq_ctl
    import flash_seq_pkg::*;
#(
    parameter int          N_MAIN    = 4,
    parameter int          PROG_CYC  = 6,
    parameter int          ERASE_CYC = 20,
    parameter logic [15:0] FILLER    = 16'h3FFF,
    localparam int         ADDR_W    = $clog2(INFO_B + N_MAIN * MAIN_SEG_B),
    localparam int         WORD_AW   = ADDR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [15:0]        op_wdata,
    output logic               rd_valid,
    output logic [15:0]        rd_data,
    output logic               busy,
    input  logic               viol_clr,
    input  logic               viol_irq_en,
    output logic               viol_flag,
    output logic               viol_irq,
    output logic               arr_rd,
    output logic               arr_wr,
    output logic               arr_ers,
    output logic [WORD_AW-1:0] arr_addr,
    output logic [15:0]        arr_wdata,
    output logic [WORD_AW-1:0] arr_ers_lo,
    output logic [WORD_AW-1:0] arr_ers_hi,
    input  logic [15:0]        arr_rdata
);
    localparam int TOTAL_W = (INFO_B + N_MAIN * MAIN_SEG_B) / 2;
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fsm_e               state;
    logic               dec_known, dec_needs_addr, dec_prog, dec_erase, dec_in_range;
    logic [WORD_AW-1:0] dec_lo, dec_hi;
    logic               accept, bad, go, viol_set;
    logic [15:0]        pat_in;
    logic [15:0]        pat_q;
    logic [WORD_AW-1:0] waddr_q;
    logic [WORD_AW-1:0] lo_q, hi_q;
    logic               rd_fill_q;
    logic               t_load, t_done;
    logic [CNT_W-1:0]   t_val;

    flash_seq_decode #(
        .N_MAIN (N_MAIN),
        .ADDR_W (ADDR_W),
        .WORD_AW(WORD_AW)
    ) u_dec (
        .op        (op_code),
        .addr      (op_addr),
        .known     (dec_known),
        .needs_addr(dec_needs_addr),
        .is_prog   (dec_prog),
        .is_erase  (dec_erase),
        .in_range  (dec_in_range),
        .rng_lo    (dec_lo),
        .rng_hi    (dec_hi)
    );

    // Request screening: acceptance, rejection and violation sources.
    always_comb begin
        busy     = (state != ST_IDLE);
        accept   = op_valid && !busy;
        bad      = accept && (!dec_known
                              || (dec_needs_addr && !dec_in_range)
                              || (op_code == OP_PWORD && op_addr[0]));
        go       = accept && !bad;
        viol_set = (op_valid && busy) || bad;
    end

    // Program pattern: the unaddressed lane of a byte program stays all ones.
    always_comb begin
        if (op_code == OP_PBYTE)
            pat_in = op_addr[0] ? {op_wdata[7:0], 8'hFF} : {8'hFF, op_wdata[7:0]};
        else
            pat_in = op_wdata;
    end

    // Operation sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (go && dec_prog)       state <= ST_PRD;
                         else if (go && dec_erase) state <= ST_ERS;
                ST_PRD:  state <= ST_PWR;
                ST_PWR:  state <= ST_WAIT;
                ST_ERS:  state <= ST_WAIT;
                ST_WAIT: if (t_done)               state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the operands of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q   <= '1;
            waddr_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (go) begin
            pat_q   <= pat_in;
            waddr_q <= op_addr[ADDR_W-1:1];
            lo_q    <= dec_lo;
            hi_q    <= dec_hi;
        end
    end

    // Read return: valid a cycle after any read request, filler unless accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_fill_q <= 1'b1;
        end else begin
            rd_valid  <= op_valid && (op_code == OP_READ);
            rd_fill_q <= !go;
        end
    end

    assign rd_data = rd_fill_q ? FILLER : arr_rdata;

    // Array strobes.
    always_comb begin
        arr_rd     = (go && op_code == OP_READ) || (state == ST_PRD);
        arr_wr     = (state == ST_PWR);
        arr_ers    = (state == ST_ERS);
        arr_addr   = (state == ST_IDLE) ? op_addr[ADDR_W-1:1] : waddr_q;
        arr_wdata  = arr_rdata & pat_q;
        arr_ers_lo = lo_q;
        arr_ers_hi = hi_q;
    end

    // Pulse timer load values.
    always_comb begin
        t_load = (state == ST_PWR) || (state == ST_ERS);
        t_val  = (state == ST_ERS) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
    end

    flash_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .done    (t_done)
    );

    flash_seq_viol u_viol (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (viol_set),
        .clr   (viol_clr),
        .irq_en(viol_irq_en),
        .flag  (viol_flag),
        .irq   (viol_irq)
    );

    p_busy_read_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && busy && op_code == OP_READ) |=> (rd_valid && rd_data == FILLER));
    p_odd_word_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == OP_PWORD && op_addr[0]) |=> (viol_flag && !busy));
    p_erase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_ers |-> (arr_ers_lo <= arr_ers_hi && arr_ers_hi < WORD_AW'(TOTAL_W)));
    p_oor_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == OP_ESEG && !dec_in_range) |=> !busy);
    p_prog_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == OP_PBYTE && dec_in_range) |=> (busy && arr_rd));
endmodule

// File: tb/sim_flash_seq_ctl.sv
module sim_flash_seq_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NM   = 4;
    localparam int PC   = 6;
    localparam int EC   = 20;
    localparam logic [15:0] FIL = 16'h3FFF;
    localparam int TB_B = 256 + 512 * NM;
    localparam int TW   = TB_B / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [11:0] op_addr = '0;
    logic [15:0] op_wdata = '0;
    logic        rd_valid, busy, viol_flag, viol_irq;
    logic [15:0] rd_data;
    logic        viol_clr = 1'b0;
    logic        viol_irq_en = 1'b0;
    logic        arr_rd, arr_wr, arr_ers;
    logic [10:0] arr_addr, arr_ers_lo, arr_ers_hi;
    logic [15:0] arr_wdata;
    logic [15:0] arr_rdata;

    logic [15:0] mem [0:TW-1];
    logic [15:0] refm [0:TW-1];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_seq_ctl #(.N_MAIN(NM), .PROG_CYC(PC), .ERASE_CYC(EC), .FILLER(FIL)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_wdata(op_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .viol_clr(viol_clr),
        .viol_irq_en(viol_irq_en), .viol_flag(viol_flag), .viol_irq(viol_irq),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_ers(arr_ers), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_ers_lo(arr_ers_lo), .arr_ers_hi(arr_ers_hi),
        .arr_rdata(arr_rdata)
    );

    function automatic logic [15:0] seed(int i);
        return 16'((i * 40503) ^ 16'hA5C3);
    endfunction

    // Behavioural flash array: registered read, word write, range erase.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TW; i++) mem[i] <= seed(i);
        end else begin
            if (arr_rd) arr_rdata <= mem[arr_addr];
            if (arr_wr) mem[arr_addr] <= arr_wdata;
            if (arr_ers)
                for (int i = 0; i < TW; i++)
                    if (i >= int'(arr_ers_lo) && i <= int'(arr_ers_hi)) mem[i] <= 16'hFFFF;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input int a, input logic [15:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_addr = 12'(a); op_wdata = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input int a, output logic [15:0] d, output logic v);
        issue(3'd0, a, 16'h0);
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic sweep(input string req);
        logic [15:0] d;
        logic v;
        for (int w = 0; w < TW; w++) begin
            rd(2 * w + (w % 2), d, v);
            chk(v && d == refm[w], req, {15'h0, v, d}, {16'h1, refm[w]});
        end
    endtask

    task automatic ref_erase(input int lo, input int hi);
        for (int w = lo; w <= hi; w++) refm[w] = 16'hFFFF;
    endtask

    task automatic seg_erase(input int a);
        int n;
        int lo;
        issue(3'd3, a, 16'h0);
        wait_idle(n);
        chk(n == EC + 1, "R7 erase busy length", n, EC + 1);
        if (a < 256) lo = (a / 128) * 64;
        else         lo = 128 + ((a - 256) / 512) * 256;
        ref_erase(lo, lo + ((a < 256) ? 63 : 255));
    endtask

    task automatic pbyte(input int a, input logic [7:0] b);
        int n;
        issue(3'd1, a, {8'h00, b});
        wait_idle(n);
        chk(n == PC + 2, "R7 program busy length", n, PC + 2);
        if (a % 2 == 1) refm[a / 2][15:8] = refm[a / 2][15:8] & b;
        else            refm[a / 2][7:0]  = refm[a / 2][7:0] & b;
    endtask

    task automatic pword(input int a, input logic [15:0] d);
        int n;
        issue(3'd2, a, d);
        wait_idle(n);
        chk(n == PC + 2, "R7 word program busy length", n, PC + 2);
        refm[a / 2] = refm[a / 2] & d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic v;
        int n;
        for (int i = 0; i < TW; i++) refm[i] = seed(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy after reset", busy, 0);
        chk(viol_flag == 1'b0, "R10 flag after reset", viol_flag, 0);
        chk(viol_irq == 1'b0, "R10 irq after reset", viol_irq, 0);
        chk(rd_valid == 1'b0, "R2 rd_valid after reset", rd_valid, 0);

        // R1 R2: full read sweep of the initial image
        sweep("R2 initial read sweep");
        rd(12'h101, d, v);
        chk(d == refm[12'h100 / 2], "R1 odd address reads its word", d, refm[12'h100 / 2]);

        // R5: byte programs in both lanes, info and main
        pbyte(12'h001, 8'h3C);
        pbyte(12'h0FE, 8'hA5);
        pbyte(12'h100, 8'h0F);
        pbyte(12'h3FF, 8'h81);
        pbyte(TB_B - 1, 8'h00);
        pbyte(12'h001, 8'hFF);
        rd(12'h000, d, v);
        chk(d == refm[0], "R5 byte program clears only", d, refm[0]);
        rd(TB_B - 2, d, v);
        chk(d == refm[TW - 1], "R5 last byte programmed", d, refm[TW - 1]);

        // R6: word programs accumulate by AND
        pword(12'h200, 16'hF0F0);
        pword(12'h200, 16'h0FF0);
        rd(12'h200, d, v);
        chk(d == (seed(12'h100) & 16'h00F0), "R6 word program AND", d, seed(12'h100) & 16'h00F0);

        // R6: odd word address rejected
        issue(3'd2, 12'h203, 16'h0000);
        chk(viol_flag == 1'b1, "R6 odd word sets flag", viol_flag, 1);
        chk(busy == 1'b0, "R6 odd word no busy", busy, 0);
        rd(12'h202, d, v);
        chk(d == refm[12'h202 / 2], "R6 odd word leaves array", d, refm[12'h202 / 2]);

        // R10: interrupt gating, clear, set-wins
        chk(viol_irq == 1'b0, "R10 irq masked", viol_irq, 0);
        @(negedge clk); viol_irq_en = 1'b1; #1;
        chk(viol_irq == 1'b1, "R10 irq enabled", viol_irq, 1);
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0;
        chk(viol_flag == 1'b0 && viol_irq == 1'b0, "R10 clear", {viol_flag, viol_irq}, 0);
        @(negedge clk);
        viol_clr = 1'b1; op_valid = 1'b1; op_code = 3'd2; op_addr = 12'h101; op_wdata = 16'h0;
        @(negedge clk);
        viol_clr = 1'b0; op_valid = 1'b0;
        chk(viol_flag == 1'b1, "R10 set wins over clear", viol_flag, 1);
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0; viol_irq_en = 1'b0;

        // R3: segment erases of both sizes
        seg_erase(12'h005);
        seg_erase(256 + 512 * 2 + 77);
        sweep("R3 erase info A and main 2");
        seg_erase(12'h0C1);
        seg_erase(256 + 3);
        sweep("R3 erase info B and main 0");

        // R4: main erase keeps info
        pbyte(12'h010, 8'h12);
        pbyte(12'h0A3, 8'h34);
        issue(3'd4, 12'hFFF, 16'h0);
        wait_idle(n);
        chk(n == EC + 1, "R7 main erase busy length", n, EC + 1);
        ref_erase(128, TW - 1);
        sweep("R4 main erase keeps info");

        // R8: operations while busy
        issue(3'd3, 12'h080, 16'h0);
        rd(12'h000, d, v);
        chk(v && d == FIL, "R8 busy read returns filler", {v, d}, {1'b1, FIL});
        chk(viol_flag == 1'b1, "R8 busy read flags", viol_flag, 1);
        issue(3'd1, 12'h010, 16'h0000);
        wait_idle(n);
        ref_erase(64, 127);
        rd(12'h010, d, v);
        chk(d == refm[8], "R8 busy program dropped", d, refm[8]);
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0;

        // R9: out-of-range and reserved codes
        rd(TB_B, d, v);
        chk(v && d == FIL, "R9 out-of-range read filler", {v, d}, {1'b1, FIL});
        chk(viol_flag == 1'b1, "R9 out-of-range read flags", viol_flag, 1);
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0;
        issue(3'd3, 12'hFFF, 16'h0);
        chk(viol_flag == 1'b1 && busy == 1'b0, "R9 out-of-range erase", {viol_flag, busy}, 2);
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0;
        issue(3'd6, 12'h010, 16'h0);
        chk(viol_flag == 1'b1 && busy == 1'b0, "R9 reserved code", {viol_flag, busy}, 2);
        issue(3'd7, 12'h010, 16'h0);
        chk(busy == 1'b0, "R9 reserved code 7 no busy", busy, 0);
        sweep("R9 array untouched by rejects");

        // R4: full erase
        issue(3'd5, 12'h000, 16'h0);
        wait_idle(n);
        chk(n == EC + 1, "R7 full erase busy length", n, EC + 1);
        ref_erase(0, TW - 1);
        sweep("R4 full erase");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule